// File: doc/BRIEF.md
# Sound Generator Host Register Interface

This block sits between a byte-wide processor bus and a three-channel sound generator that has sixteen internal registers. The processor reaches it through a two-bit offset. Offset bit 1 picks between an 8-bit index latch and the data port that the index points at. Offset bit 0 marks a shadow alias. The block holds the sixteen registers itself and trims the unused high bits of certain registers as they are written. It keeps a separate read-back latch whose content is what a read at offset 0 returns.

Every accepted write to one of the fourteen sound registers is forwarded to the sound engine in the same cycle as a one-cycle pulse that carries the register index and the trimmed value. After reset the block replays a zero into each of those fourteen registers, one per cycle, so the engine starts from a known state. Every accepted access also raises a one-cycle wait request toward the bus master.

Top module: `sndreg_host_if`

## Requirements
- R1: Offset bit 1 selects the target: 0 addresses the index latch and 1 addresses the data port. At the shadow offsets 1 and 3, a write takes effect only when `bus_byte` is 1. A wider write there changes nothing and raises no wait request.
- R2: The index latch keeps all 8 written bits. An index of 16 or more is invalid: data-port writes are dropped, with no aliasing onto a lower register, and reads at offset 0 return 0xFF.
- R3: A read returns register content only at offset 0. Reads at offsets 1, 2 and 3, and any cycle without an access, give 0xFF on `bus_rdata`.
- R4: Stored values are trimmed on write. Registers 1, 3, 5 and 13 keep bits 3:0. Registers 6, 8, 9 and 10 keep bits 4:0. All other registers, including 14 and 15, keep all 8 bits.
- R5: A valid data-port write loads the read-back latch with the raw, untrimmed byte. Later reads at offset 0 return that byte until the index latch is written again.
- R6: A write to the index latch loads the read-back latch with the stored, trimmed content of the newly selected register, or with 0xFF if the new index is 16 or more.
- R7: `wait_req` is 1 in exactly the cycles that carry an accepted access. Accepted accesses are reads at any offset, writes at offsets 0 and 2, and byte-size writes at offsets 1 and 3.
- R8: A valid data-port write to registers 0 to 13 raises `eng_we` in the same cycle, with `eng_idx` equal to the index and `eng_val` equal to the trimmed value. Writes to registers 14 and 15, and dropped writes, give no pulse.
- R9: Reset clears the index latch, the read-back latch and all registers, and holds `eng_we` at 0. After reset is released, the engine receives pulses with value 0 for indices 0 to 13, one per cycle. A host engine write in that window takes the port for its cycle, and the replay continues with the same index in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Offset; bit 1 = data port, bit 0 = shadow alias |
| bus_byte | input | 1 | 1 = byte-size access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| wait_req | output | 1 | One-cycle wait request for an accepted access |
| eng_we | output | 1 | Sound engine register write pulse |
| eng_idx | output | 4 | Sound engine register index |
| eng_val | output | 8 | Sound engine register value |

## Verification
The hardest state to reach is a collision: a host write to a sound register that falls inside the post-reset replay window. The bench gets there by releasing reset and issuing an index write and then a data write within the next two cycles. It then checks that the host pulse wins the port and that the replay resumes at the stalled index. A second hard case is telling the raw read-back apart from the trimmed stored value. Each masked register is written with high bits set, read back once without reselecting, and read again after reselecting. An out-of-range index followed by a data write and a reselect of register 0 shows that no aliasing occurred.

// File: rtl/sndreg_pkg.sv
`timescale 1ns/1ps
package sndreg_pkg;

   // Number of meaningful low bits a register keeps on write.
   function automatic int unsigned kept_bits(int unsigned idx, int unsigned dw);
      case (idx)
         1, 3, 5, 13:   return 4;
         6, 8, 9, 10:   return 5;
         default:       return dw;
      endcase
   endfunction

endpackage

// File: rtl/sndreg_decode.sv
`timescale 1ns/1ps
module sndreg_decode (
   input  logic       cs,
   input  logic       we,
   input  logic [1:0] addr,
   input  logic       byte_sz,
   output logic       accept,
   output logic       sel_wr,
   output logic       dat_wr,
   output logic       main_rd
);
   // shadow offsets (bit 0 set) accept writes only at byte size
   assign accept  = cs & (~we | ~addr[0] | byte_sz);
   assign sel_wr  = accept & we & ~addr[1];
   assign dat_wr  = accept & we &  addr[1];
   assign main_rd = cs & ~we & (addr == 2'd0);
endmodule

// File: rtl/sndreg_file.sv
`timescale 1ns/1ps
module sndreg_file #(
   parameter int DW   = 8,
   parameter int NREG = 16,
   parameter int IW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] wr_trim,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);
   import sndreg_pkg::*;

   logic [DW-1:0] q      [NREG];
   logic [DW-1:0] mask_a [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam int unsigned UB = kept_bits(i, DW);
      localparam logic [DW-1:0] MASK = {DW{1'b1}} >> (DW - UB);
      logic [DW-1:0] r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r <= '0;
         else if (wr_en && wr_idx == IW'(i))
            r <= wr_data & MASK;
      end

      assign q[i]      = r;
      assign mask_a[i] = MASK;
   end

   assign wr_trim = wr_data & mask_a[wr_idx];
   assign rd_data = q[rd_idx];
endmodule

// File: rtl/sndreg_flush.sv
`timescale 1ns/1ps
module sndreg_flush #(
   parameter int NSND = 14,
   parameter int IW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   output logic          fl_we,
   output logic [IW-1:0] fl_idx
);
   localparam int CW = $clog2(NSND + 1);
   localparam logic [CW-1:0] LAST = CW'(NSND);

   logic [CW-1:0] cnt;

   assign fl_we  = rst_n & (cnt < LAST);
   assign fl_idx = IW'(cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (fl_we && !hold)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sndreg_host_if.sv
`timescale 1ns/1ps
module sndreg_host_if #(
   parameter int DW   = 8,
   parameter int NREG = 16,
   parameter int NSND = 14,
   parameter int IW   = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_cs,
   input  logic          bus_we,
   input  logic [1:0]    bus_addr,
   input  logic          bus_byte,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          wait_req,
   output logic          eng_we,
   output logic [IW-1:0] eng_idx,
   output logic [DW-1:0] eng_val
);
   localparam logic [DW-1:0] NREG_V = DW'(NREG);
   localparam logic [DW-1:0] NSND_V = DW'(NSND);

   if (NREG != (1 << IW)) begin : g_bad_nreg
      $error("NREG must be a power of two matching IW");
   end
   if (NSND > NREG) begin : g_bad_nsnd
      $error("NSND must not exceed NREG");
   end
   if (DW <= IW) begin : g_bad_dw
      $error("DW must be wider than the register index");
   end

   logic          accept, sel_wr, dat_wr, main_rd;
   logic [DW-1:0] sel_q, rb_q;
   logic          sel_ok, dat_ok, host_eng;
   logic [DW-1:0] trim_val, lookup_val;
   logic          fl_we;
   logic [IW-1:0] fl_idx;

   sndreg_decode u_dec (
      .cs      (bus_cs),
      .we      (bus_we),
      .addr    (bus_addr),
      .byte_sz (bus_byte),
      .accept  (accept),
      .sel_wr  (sel_wr),
      .dat_wr  (dat_wr),
      .main_rd (main_rd)
   );

   assign sel_ok   = sel_q < NREG_V;
   assign dat_ok   = dat_wr & sel_ok;
   assign host_eng = dat_ok & (sel_q < NSND_V);

   sndreg_file #(.DW(DW), .NREG(NREG), .IW(IW)) u_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dat_ok),
      .wr_idx  (sel_q[IW-1:0]),
      .wr_data (bus_wdata),
      .wr_trim (trim_val),
      .rd_idx  (bus_wdata[IW-1:0]),
      .rd_data (lookup_val)
   );

   sndreg_flush #(.NSND(NSND), .IW(IW)) u_flush (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (host_eng),
      .fl_we  (fl_we),
      .fl_idx (fl_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         rb_q  <= '0;
      end else if (sel_wr) begin
         sel_q <= bus_wdata;
         rb_q  <= (bus_wdata < NREG_V) ? lookup_val : '1;
      end else if (dat_ok) begin
         rb_q  <= bus_wdata;
      end
   end

   assign wait_req  = accept;
   assign bus_rdata = (main_rd && sel_ok) ? rb_q : '1;
   assign eng_we    = host_eng | fl_we;
   assign eng_idx   = host_eng ? sel_q[IW-1:0] : fl_idx;
   assign eng_val   = host_eng ? trim_val : '0;
endmodule

// File: rtl/sndreg_chk.sv
`timescale 1ns/1ps
module sndreg_chk #(
   parameter int DW   = 8,
   parameter int NREG = 16,
   parameter int NSND = 14,
   parameter int IW   = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_cs,
   input logic          bus_we,
   input logic [1:0]    bus_addr,
   input logic          bus_byte,
   input logic [DW-1:0] bus_wdata,
   input logic [DW-1:0] bus_rdata,
   input logic          wait_req,
   input logic          eng_we,
   input logic [IW-1:0] eng_idx,
   input logic [DW-1:0] eng_val,
   input logic [DW-1:0] sel_q,
   input logic [DW-1:0] rb_q
);
   localparam logic [DW-1:0] NREG_V = DW'(NREG);
   localparam logic [IW-1:0] NSND_V = IW'(NSND);

   // R1
   shadow_wide_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs && bus_we && bus_addr[0] && !bus_byte |-> !wait_req);

   // R1
   shadow_wide_no_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs && bus_we && bus_addr[0] && !bus_byte |=> $stable(sel_q) && $stable(rb_q));

   // R2
   invalid_sel_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs && !bus_we && bus_addr == 2'd0 && sel_q >= NREG_V |-> bus_rdata == {DW{1'b1}});

   // R3
   side_offset_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs && !bus_we && bus_addr != 2'd0 |-> bus_rdata == {DW{1'b1}});

   // R4
   env_shape_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we && eng_idx == IW'(13) |-> eng_val[DW-1:4] == '0);

   // R5
   raw_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs && bus_we && bus_addr == 2'b10 && sel_q < NREG_V |=> rb_q == $past(bus_wdata));

   // R7
   wait_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_req |-> bus_cs);

   // R8
   engine_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we |-> eng_idx < NSND_V);
endmodule

bind sndreg_host_if sndreg_chk #(.DW(DW), .NREG(NREG), .NSND(NSND), .IW(IW)) i_chk (.*);

// File: tb/test_sndreg_host_if.sv
`timescale 1ns/1ps
module test_sndreg_host_if;
   localparam time CYC = 20ns;
   localparam int  VW  = 39;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_cs = 1'b0, bus_we = 1'b0, bus_byte = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata, eng_val;
   logic       wait_req, eng_we;
   logic [3:0] eng_idx;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CYC/2) clk = ~clk;

   sndreg_host_if i_sndreg_host_if (
      .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wait_req(wait_req), .eng_we(eng_we),
      .eng_idx(eng_idx), .eng_val(eng_val)
   );

   // fields: req, cs, we, addr, byte, wdata, exp rdata, exp wait, exp eng_we, exp idx, exp val
   function automatic logic [VW-1:0] mk(int r, bit cs, bit we, int a, bit b, int wd,
                                        int rd, bit wt, bit ew, int ix, int vl);
      return {4'(r), cs, we, 2'(a), b, 8'(wd), 8'(rd), wt, ew, 4'(ix), 8'(vl)};
   endfunction

   localparam int NV = 33;
   localparam logic [VW-1:0] VEC [NV] = '{
      mk(7, 1,1,0,1, 8'h03, 8'hFF, 1,0, 0,8'h00), // R7 select 3
      mk(4, 1,1,2,0, 8'h5A, 8'hFF, 1,1, 3,8'h0A), // R4 wide data write, trimmed to 3:0
      mk(5, 1,0,0,1, 8'h00, 8'h5A, 1,0, 0,8'h00), // R5 raw byte read back
      mk(3, 1,0,1,1, 8'h00, 8'hFF, 1,0, 0,8'h00), // R3 offset 1 read
      mk(3, 1,0,2,1, 8'h00, 8'hFF, 1,0, 0,8'h00), // R3 offset 2 read
      mk(3, 1,0,3,0, 8'h00, 8'hFF, 1,0, 0,8'h00), // R3 offset 3 read
      mk(6, 1,1,0,1, 8'h03, 8'hFF, 1,0, 0,8'h00), // R6 reselect 3
      mk(6, 1,0,0,1, 8'h00, 8'h0A, 1,0, 0,8'h00), // R6 trimmed content
      mk(1, 1,1,1,0, 8'h08, 8'hFF, 0,0, 0,8'h00), // R1 wide shadow select ignored
      mk(1, 1,0,0,1, 8'h00, 8'h0A, 1,0, 0,8'h00), // R1 select unchanged
      mk(1, 1,1,1,1, 8'h08, 8'hFF, 1,0, 0,8'h00), // R1 byte shadow select 8
      mk(8, 1,1,3,1, 8'hF3, 8'hFF, 1,1, 8,8'h13), // R8 shadow data write, 4:0 kept
      mk(5, 1,0,0,1, 8'h00, 8'hF3, 1,0, 0,8'h00), // R5 raw
      mk(1, 1,1,3,0, 8'h77, 8'hFF, 0,0, 0,8'h00), // R1 wide shadow data ignored
      mk(6, 1,1,0,1, 8'h08, 8'hFF, 1,0, 0,8'h00), // R6 reselect 8
      mk(6, 1,0,0,1, 8'h00, 8'h13, 1,0, 0,8'h00), // R6 value untouched by wide write
      mk(2, 1,1,0,1, 8'h10, 8'hFF, 1,0, 0,8'h00), // R2 select 0x10
      mk(2, 1,0,0,1, 8'h00, 8'hFF, 1,0, 0,8'h00), // R2 invalid read
      mk(2, 1,1,2,1, 8'h44, 8'hFF, 1,0, 0,8'h00), // R2 dropped write
      mk(2, 1,1,0,1, 8'h00, 8'hFF, 1,0, 0,8'h00), // R2 select 0
      mk(2, 1,0,0,1, 8'h00, 8'h00, 1,0, 0,8'h00), // R2 reg 0 not aliased
      mk(8, 1,1,0,1, 8'h0E, 8'hFF, 1,0, 0,8'h00), // R8 select 14
      mk(8, 1,1,2,1, 8'hAB, 8'hFF, 1,0, 0,8'h00), // R8 no pulse for 14
      mk(5, 1,0,0,1, 8'h00, 8'hAB, 1,0, 0,8'h00), // R5
      mk(4, 1,1,0,1, 8'h0E, 8'hFF, 1,0, 0,8'h00), // R4 reselect 14
      mk(4, 1,0,0,1, 8'h00, 8'hAB, 1,0, 0,8'h00), // R4 reg 14 keeps 8 bits
      mk(4, 1,1,0,1, 8'h06, 8'hFF, 1,0, 0,8'h00), // R4 select 6
      mk(4, 1,1,2,1, 8'hE5, 8'hFF, 1,1, 6,8'h05), // R4 noise period trim
      mk(4, 1,1,0,1, 8'h0D, 8'hFF, 1,0, 0,8'h00), // R4 select 13
      mk(4, 1,1,2,1, 8'hFE, 8'hFF, 1,1,13,8'h0E), // R4 shape trim
      mk(6, 1,1,0,1, 8'h0D, 8'hFF, 1,0, 0,8'h00), // R6 reselect 13
      mk(6, 1,0,0,1, 8'h00, 8'h0E, 1,0, 0,8'h00), // R6
      mk(7, 0,0,0,0, 8'h00, 8'hFF, 0,0, 0,8'h00)  // R7 idle cycle
   };

   task automatic check(input int req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input bit cs, input bit we, input int a, input bit b, input int wd);
      @(negedge clk);
      bus_cs = cs; bus_we = we; bus_addr = 2'(a); bus_byte = b; bus_wdata = 8'(wd);
      #5;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CYC * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      // R9 during reset
      drive(0,0,0,0,0);
      check(9, eng_we, 0, "eng_we in reset");
      check(9, wait_req, 0, "wait in reset");
      check(3, bus_rdata, 8'hFF, "idle rdata");
      @(negedge clk); rst_n = 1'b1; #5;
      for (int k = 0; k < 14; k++) begin
         if (k > 0) begin @(negedge clk); #5; end
         check(9, eng_we, 1, "replay pulse");
         check(9, eng_idx, k, "replay index");
         check(9, eng_val, 0, "replay value");
      end
      drive(0,0,0,0,0);
      check(9, eng_we, 0, "replay done");
      drive(1,0,0,1,0);
      check(9, bus_rdata, 8'h00, "read after reset");

      // table walk
      for (int k = 0; k < NV; k++) begin
         logic [VW-1:0] v;
         v = VEC[k];
         drive(v[34], v[33], int'(v[32:31]), v[30], int'(v[29:22]));
         check(int'(v[38:35]), bus_rdata, int'(v[21:14]), "rdata");
         check(int'(v[38:35]), wait_req, int'(v[13]), "wait_req");
         check(int'(v[38:35]), eng_we, int'(v[12]), "eng_we");
         if (v[12]) begin
            check(int'(v[38:35]), eng_idx, int'(v[11:8]), "eng_idx");
            check(int'(v[38:35]), eng_val, int'(v[7:0]), "eng_val");
         end
      end

      // R9 second reset with host write inside the replay window
      drive(0,0,0,0,0);
      rst_n = 1'b0; #1;
      check(9, eng_we, 0, "eng_we held in reset");
      @(negedge clk); rst_n = 1'b1; #5;
      check(9, eng_idx, 0, "replay restart");
      drive(1,1,0,1,8'h02);
      check(9, eng_idx, 1, "replay during select write");
      drive(1,1,2,1,8'h99);
      check(9, eng_idx, 2, "host index wins");
      check(9, eng_val, 8'h99, "host value wins");
      drive(0,0,0,0,0);
      check(9, eng_we, 1, "replay resumes");
      check(9, eng_idx, 2, "replay resumes at stalled index");
      check(9, eng_val, 0, "replay resumes value");
      for (int k = 3; k < 14; k++) begin
         @(negedge clk); #5;
         check(9, eng_idx, k, "replay index after stall");
      end
      drive(0,0,0,0,0);
      check(9, eng_we, 0, "replay done after stall");
      drive(1,1,0,1,8'h03);
      drive(1,0,0,1,0);
      check(9, bus_rdata, 8'h00, "reg 3 cleared by reset");
      drive(0,0,0,0,0);

      done = 1'b1;
      finish_run();
   end
endmodule